// File: doc/BRIEF.md
# Priority Threshold Interrupt Arbiter

This block is the per-target selection stage of a platform interrupt controller. Each cycle it looks at a vector of pending flags, a vector of enable flags, one priority value per source and the target's threshold. Among the sources that are both pending and enabled, it finds the one with the highest priority. On the next clock edge it registers that source's identifier and a flag telling whether the interrupt line should be raised.

The interrupt line `irq_o` is raised only when the winning priority is strictly greater than the threshold. The identifier output `irq_id_o` follows the best candidate even when the threshold holds the line low, so a target can see which source would be next. Identifier 0 is reserved and means that no source qualifies. A source with priority 0 never qualifies. The logic that sets pending flags, the register file and the bus interface sit outside this block.

Top module: `plic_target_arbiter`

## Requirements
- R1: A source takes part in selection only when both its enable bit and its pending bit are 1. Bit i of `pending_i` and `enable_i` belongs to the source with ID i+1.
- R2: A source whose priority field is 0 is never selected, even when it is pending and enabled.
- R3: The selected source has the highest priority among the qualifying sources. When several share that priority, the one with the lowest ID is selected. The priority of the source with ID i+1 is `prio_i[i*PRIO_W +: PRIO_W]`.
- R4: `irq_o` is 1 exactly when the selected priority is strictly greater than `threshold_i`. A priority equal to the threshold does not raise it.
- R5: `irq_id_o` carries the selected source's ID whether or not `irq_o` is 1.
- R6: When no source qualifies, `irq_id_o` is 0 and `irq_o` is 0.
- R7: While `rst_ni` is 0, both outputs are cleared to 0 at each clock edge.
- R8: Both outputs reflect the inputs sampled at the previous rising clock edge only. Input changes between edges have no effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| pending_i | input | N | Pending flag per source, bit i is ID i+1 |
| enable_i | input | N | Enable flag per source, bit i is ID i+1 |
| prio_i | input | N*PRIO_W | Packed priorities, field i is ID i+1 |
| threshold_i | input | PRIO_W | Target threshold |
| irq_o | output | 1 | Registered interrupt request |
| irq_id_o | output | IDW | Registered ID of the best candidate, 0 for none |

## Verification
The bench builds the block with N = 7 and PRIO_W = 3. Seven sources do not fill a power-of-two tree, so the padded leaves and the last real leaf (ID 7) are both exercised. A three-bit priority gives only eight levels, so random stimulus often produces ties, zero priorities and priorities equal to the threshold. With a three-bit ID, every legal ID and the reserved 0 show up often.

// File: rtl/plic_arb_pkg.sv
// Package: shared sizing helpers for the target interrupt arbiter.
// Assumes: source count of at least 1.
package plic_arb_pkg;

    // Bits needed to carry IDs 0..n, where 0 means "no source".
    function automatic int unsigned id_bits(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Depth of a binary tree covering n leaves (at least one level).
    function automatic int unsigned tree_levels(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/plic_arb_mask.sv
// Module: plic_arb_mask
// Turns the raw per-source inputs into tree leaves. A source that is not
// both pending and enabled, or whose priority is 0, becomes an empty leaf
// (priority 0, ID 0). A qualifying leaf carries its own ID, index + 1.
// Assumes: IDW can hold the value N.
module plic_arb_mask #(
    parameter int unsigned N      = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDW    = 6
) (
    input  logic [N-1:0]        pending_i,
    input  logic [N-1:0]        enable_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic [N*PRIO_W-1:0] leaf_prio_o,
    output logic [N*IDW-1:0]    leaf_id_o
);

    for (genvar s = 0; s < N; s++) begin : g_src
        logic [PRIO_W-1:0] raw_prio;
        logic              qualifies;

        assign raw_prio  = prio_i[s*PRIO_W +: PRIO_W];
        // Candidate: pending, enabled and of nonzero priority.
        assign qualifies = pending_i[s] & enable_i[s] & (raw_prio != '0);

        assign leaf_prio_o[s*PRIO_W +: PRIO_W] = qualifies ? raw_prio : '0;
        assign leaf_id_o[s*IDW +: IDW]         = qualifies ? IDW'(s + 1) : '0;
    end

endmodule

// File: rtl/plic_arb_tree.sv
// Module: plic_arb_tree
// Binary tournament over the leaves. Each node keeps the left entry unless
// the right entry's priority is strictly greater. The left subtree always
// holds lower IDs, so a tie resolves to the lowest ID. Leaves past N are
// padded with empty entries, and an empty root yields ID 0.
// Assumes: empty leaves carry priority 0 and ID 0.
module plic_arb_tree #(
    parameter int unsigned N      = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDW    = 6,
    parameter int unsigned LEVELS = 5
) (
    input  logic [N*PRIO_W-1:0] leaf_prio_i,
    input  logic [N*IDW-1:0]    leaf_id_i,
    output logic [PRIO_W-1:0]   win_prio_o,
    output logic [IDW-1:0]      win_id_o
);

    localparam int unsigned LEAVES = 1 << LEVELS;
    localparam int unsigned NODES  = 2 * LEAVES - 1;
    localparam int unsigned FIRST  = LEAVES - 1;

    logic [PRIO_W-1:0] node_prio [NODES];
    logic [IDW-1:0]    node_id   [NODES];

    // Leaf layer: real sources first, empty padding after them.
    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < N) begin : g_real
            assign node_prio[FIRST + l] = leaf_prio_i[l*PRIO_W +: PRIO_W];
            assign node_id[FIRST + l]   = leaf_id_i[l*IDW +: IDW];
        end else begin : g_pad
            assign node_prio[FIRST + l] = '0;
            assign node_id[FIRST + l]   = '0;
        end
    end

    // Inner nodes: node k compares children 2k+1 (left) and 2k+2 (right).
    for (genvar k = 0; k < FIRST; k++) begin : g_node
        logic right_wins;
        assign right_wins   = node_prio[2*k + 2] > node_prio[2*k + 1];
        assign node_prio[k] = right_wins ? node_prio[2*k + 2] : node_prio[2*k + 1];
        assign node_id[k]   = right_wins ? node_id[2*k + 2]   : node_id[2*k + 1];
    end

    assign win_prio_o = node_prio[0];
    assign win_id_o   = node_id[0];

endmodule

// File: rtl/plic_arb_out.sv
// Module: plic_arb_out
// The single register stage. It stores the winning ID and whether the
// winning priority is strictly greater than the threshold.
// Assumes: an empty winner arrives as priority 0 and ID 0.
module plic_arb_out #(
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDW    = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PRIO_W-1:0] win_prio_i,
    input  logic [IDW-1:0]    win_id_i,
    input  logic [PRIO_W-1:0] threshold_i,
    output logic              irq_o,
    output logic [IDW-1:0]    irq_id_o
);

    logic above;
    assign above = win_prio_i > threshold_i;

    // Register the request and the ID, clearing both on synchronous reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_o    <= 1'b0;
            irq_id_o <= '0;
        end else begin
            irq_o    <= above;
            irq_id_o <= win_id_i;
        end
    end

endmodule

// File: rtl/plic_target_arbiter.sv
// Module: plic_target_arbiter (top)
// Per-target selection of the highest-priority pending and enabled
// interrupt source. The selection is combinational and is followed by one
// register stage. The ID output follows the best candidate even when the
// threshold keeps the request low.
// Assumes: synchronous active-low reset; source i of the vectors is ID i+1.
module plic_target_arbiter
    import plic_arb_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDW    = id_bits(N)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N-1:0]        pending_i,
    input  logic [N-1:0]        enable_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]   threshold_i,
    output logic                irq_o,
    output logic [IDW-1:0]      irq_id_o
);

    localparam int unsigned LEVELS = tree_levels(N);

    logic [N*PRIO_W-1:0] leaf_prio;
    logic [N*IDW-1:0]    leaf_id;
    logic [PRIO_W-1:0]   win_prio;
    logic [IDW-1:0]      win_id;

    plic_arb_mask #(.N(N), .PRIO_W(PRIO_W), .IDW(IDW)) u_mask (
        .pending_i   (pending_i),
        .enable_i    (enable_i),
        .prio_i      (prio_i),
        .leaf_prio_o (leaf_prio),
        .leaf_id_o   (leaf_id)
    );

    plic_arb_tree #(.N(N), .PRIO_W(PRIO_W), .IDW(IDW), .LEVELS(LEVELS)) u_tree (
        .leaf_prio_i (leaf_prio),
        .leaf_id_i   (leaf_id),
        .win_prio_o  (win_prio),
        .win_id_o    (win_id)
    );

    plic_arb_out #(.PRIO_W(PRIO_W), .IDW(IDW)) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .win_prio_i  (win_prio),
        .win_id_i    (win_id),
        .threshold_i (threshold_i),
        .irq_o       (irq_o),
        .irq_id_o    (irq_id_o)
    );

endmodule

// File: rtl/plic_target_arbiter_chk.sv
// Module: plic_target_arbiter_chk
// Checker bound to the top. It keeps a linear-scan reference of the best
// candidate and relates the registered outputs to it one cycle later.
// Assumes: same parameters as the top it is bound to.
module plic_target_arbiter_chk #(
    parameter int unsigned N      = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDW    = 6
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [N-1:0]        pending_i,
    input logic [N-1:0]        enable_i,
    input logic [N*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]   threshold_i,
    input logic                irq_o,
    input logic [IDW-1:0]      irq_id_o
);

    logic [PRIO_W-1:0] ref_prio;
    logic [IDW-1:0]    ref_id;

    // Linear scan: the first strictly higher qualifying priority replaces the best.
    always_comb begin
        ref_prio = '0;
        ref_id   = '0;
        for (int s = 0; s < N; s++) begin
            if (pending_i[s] && enable_i[s] && prio_i[s*PRIO_W +: PRIO_W] > ref_prio) begin
                ref_prio = prio_i[s*PRIO_W +: PRIO_W];
                ref_id   = IDW'(s + 1);
            end
        end
    end

    // R7: a reset edge leaves both outputs at 0.
    p_reset_clear_r7: assert property (@(posedge clk_i)
        !rst_ni |=> (irq_o == 1'b0 && irq_id_o == '0));

    // R3, R5: the registered ID is the best candidate of the cycle before.
    p_id_follows_best_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> irq_id_o == $past(ref_id));

    // R4: the request rises when the best priority exceeds the threshold.
    p_irq_forward_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_prio > threshold_i) |=> irq_o);

    // R4: a raised request needs a qualifying source above threshold one cycle back.
    p_irq_backward_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(ref_prio > threshold_i));

    // R6: with no qualifying source, both outputs are 0 next cycle.
    p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_prio == '0) |=> (!irq_o && irq_id_o == '0));

    // R2, R4: a raised request always names a real source.
    p_irq_has_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> irq_id_o != '0);

endmodule

bind plic_target_arbiter plic_target_arbiter_chk #(
    .N(N), .PRIO_W(PRIO_W), .IDW(IDW)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (pending_i),
    .enable_i    (enable_i),
    .prio_i      (prio_i),
    .threshold_i (threshold_i),
    .irq_o       (irq_o),
    .irq_id_o    (irq_id_o)
);

// File: tb/test_plic_target_arbiter.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random vectors. Each
// output is compared one edge after its inputs against a bench-side model.
module test_plic_target_arbiter;

    localparam int unsigned N  = 7;
    localparam int unsigned PW = 3;
    localparam int unsigned IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    pend = '0;
    logic [N-1:0]    en = '0;
    logic [N*PW-1:0] prio = '0;
    logic [PW-1:0]   thr = '0;
    logic            irq;
    logic [IW-1:0]   irq_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    plic_target_arbiter #(.N(N), .PRIO_W(PW), .IDW(IW)) i_plic_target_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .pending_i(pend), .enable_i(en),
        .prio_i(prio), .threshold_i(thr), .irq_o(irq), .irq_id_o(irq_id)
    );

    // Expected ID: highest qualifying nonzero priority, lowest ID on ties.
    function automatic logic [IW-1:0] exp_id(input logic [N-1:0] p, input logic [N-1:0] e,
                                             input logic [N*PW-1:0] pr);
        logic [PW-1:0] best = '0;
        logic [IW-1:0] id = '0;
        for (int s = 0; s < N; s++)
            if (p[s] && e[s] && pr[s*PW +: PW] > best) begin
                best = pr[s*PW +: PW];
                id = IW'(s + 1);
            end
        return id;
    endfunction

    // Expected request: that best priority strictly above the threshold.
    function automatic logic exp_irq(input logic [N-1:0] p, input logic [N-1:0] e,
                                     input logic [N*PW-1:0] pr, input logic [PW-1:0] t);
        logic [PW-1:0] best = '0;
        for (int s = 0; s < N; s++)
            if (p[s] && e[s] && pr[s*PW +: PW] > best) best = pr[s*PW +: PW];
        return best > t;
    endfunction

    task automatic check(input string tag, input logic a_irq, input logic [IW-1:0] a_id,
                         input logic e_irq, input logic [IW-1:0] e_id);
        checks++;
        if (a_irq !== e_irq || a_id !== e_id) begin
            fails++;
            $display("FAIL %s: irq=%0b id=%0d expected irq=%0b id=%0d", tag, a_irq, a_id, e_irq, e_id);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
    task automatic apply(input string tag, input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N*PW-1:0] pr, input logic [PW-1:0] t);
        pend = p; en = e; prio = pr; thr = t;
        @(posedge clk);
        @(negedge clk);
        check(tag, irq, irq_id, exp_irq(p, e, pr, t), exp_id(p, e, pr));
    endtask

    function automatic logic [N*PW-1:0] one_prio(input int s, input logic [PW-1:0] v);
        logic [N*PW-1:0] r = '0;
        r[s*PW +: PW] = v;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N*PW-1:0] pr;
        void'($urandom(32'd20240611));
        // R7: outputs clear under reset even with a strong candidate present.
        @(negedge clk);
        pend = '1; en = '1; prio = '1; thr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 reset", irq, irq_id, 1'b0, '0);
        rst_n = 1'b1;

        apply("R6 nothing pending", '0, '1, '1, '0);
        apply("R1 pending but disabled", '1, '0, '1, '0);
        apply("R1 enabled but idle", '0, '1, '1, '0);
        apply("R1 only source 4 both set", 7'b0001000, 7'b0101000, '1, 3'd2);
        check("R1 id of bit 3", irq, irq_id, 1'b1, 3'd4);
        apply("R2 zero priority", 7'b0000100, 7'b0000100, '0, '0);
        check("R2 zero priority id", irq, irq_id, 1'b0, 3'd0);
        pr = one_prio(1, 3'd5) | one_prio(4, 3'd5) | one_prio(6, 3'd2);
        apply("R3 tie", '1, '1, pr, 3'd1);
        check("R3 tie lowest id", irq, irq_id, 1'b1, 3'd2);
        apply("R3 last source", 7'b1000000, 7'b1000000, one_prio(6, 3'd1), '0);
        check("R3 source 7", irq, irq_id, 1'b1, 3'd7);
        apply("R4 R5 equal threshold", 7'b0010000, '1, one_prio(4, 3'd4), 3'd4);
        check("R5 suppressed id", irq, irq_id, 1'b0, 3'd5);
        apply("R4 one below", 7'b0010000, '1, one_prio(4, 3'd4), 3'd3);
        check("R4 strict greater", irq, irq_id, 1'b1, 3'd5);
        apply("R5 max threshold", '1, '1, '1, 3'd7);
        check("R5 max threshold id", irq, irq_id, 1'b0, 3'd1);

        // R8: a change after the edge is invisible until the next edge.
        apply("R8 setup", 7'b0000001, 7'b0000001, one_prio(0, 3'd6), 3'd0);
        pend = 7'b0100000; en = 7'b0100000; prio = one_prio(5, 3'd7);
        #5;
        check("R8 hold between edges", irq, irq_id, 1'b1, 3'd1);
        @(posedge clk);
        @(negedge clk);
        check("R8 after edge", irq, irq_id, 1'b1, 3'd6);

        // R7: reset in the middle of activity clears outputs.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 mid-run reset", irq, irq_id, 1'b0, '0);
        rst_n = 1'b1;

        // R1 R3 R4 R5 R6: random vectors, varied density.
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] rp = N'($urandom);
            logic [N-1:0] re = N'($urandom);
            logic [N*PW-1:0] rpr = (N*PW)'($urandom);
            if (n % 4 == 0) rp = rp & N'($urandom);
            apply("R3 R4 R5 random", rp, re, rpr, PW'($urandom));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule